// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces horizontal sync, vertical sync, data-enable and pixel coordinates for a progressive display. Software sets the timing through a small word-addressed write port. Each axis passes through four regions in a fixed order: sync pulse, back porch, active data, then front porch. Every region length is written as its count minus one. The horizontal axis advances once per pixel clock, and the vertical axis advances once per completed line.

Timing writes go into staging registers. The counters only see those values at the next frame boundary, so a frame already in progress keeps its shape. A polarity mask selects the active level of each output. A command bit starts and stops the raster. A four-source interrupt set records events and drives a single interrupt line. The sources are frame-fetch-done, bus error, the per-frame vsync event and underrun.

Top module: `raster_timing_gen`

## Requirements
- R1: Each axis runs its regions in the order sync, back porch, active, front porch. A region programmed with value N lasts N+1 units. Horizontal units are clocks and vertical units are lines. The frame wraps from the last front-porch line back to the first sync clock.
- R2: Polarity register bits select the active-high level of each output when set: bit 0 vsync, bit 1 hsync, bit 2 data-enable. Bit 3 appears on `data_pol` and bit 4 on `pclk_pol`. Polarity takes effect immediately.
- R3: While command bit 0 is 0, the counters are held at the frame start and hsync, vsync and data-enable sit at their inactive levels. Setting the bit starts output at the first sync clock of a frame on the next cycle.
- R4: `pos_x` and `pos_y` give the offset inside the active region while data-enable is asserted, from 0 up to the programmed value, and they read 0 otherwise.
- R5: The vsync interrupt event (raw bit 2) fires once per frame, on the first clock of the vertical sync region. The raw bit reads set from the following cycle.
- R6: Pulses on `ev_fetch_done`, `ev_bus_err` and `ev_underrun` set raw bits 0, 1 and 3. Raw bits stay set until cleared.
- R7: Writing 1s to the clear register clears the matching raw bits. Bits written as 0 are left alone.
- R8: Status reads as raw AND mask, and `irq` is the OR of the status bits.
- R9: Timing writes made while running take effect at the first clock of the next frame. The current frame completes with the old values.
- R10: After reset the staged timing is 1680x1050 with hsync 32, h back porch 80, h front porch 48, vsync 6, v back porch 21, v front porch 3, and both syncs active high. Polarity resets to 0x07 and command resets to 0.
- R11: The register word addresses are: 0 command, 1 polarity, 2 to 5 the horizontal sync/back/active/front, 6 to 9 the vertical sync/back/active/front, 10 raw status, 11 clear (write only), 12 mask, 13 status. Timing registers read back their staged values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register word address for reads |
| rd_data | output | 32 | Combinational read data |
| ev_fetch_done | input | 1 | Frame fetch done event pulse |
| ev_bus_err | input | 1 | Bus error event pulse |
| ev_underrun | input | 1 | Underrun event pulse |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Data-enable at programmed polarity |
| data_pol | output | 1 | Data active-level select (polarity bit 3) |
| pclk_pol | output | 1 | Pixel clock edge select (polarity bit 4) |
| pos_x | output | 12 | Pixel column within active region |
| pos_y | output | 12 | Pixel row within active region |
| irq | output | 1 | OR of masked interrupt status |

## Verification
The raster is compared cycle by cycle against a bench model under several timings. The first is a hand-picked small timing. Then come random region lengths with random polarity, the degenerate case where every region is one unit long, and the first lines of the default 1680x1050 mode. Between them, these separate off-by-one errors in each region and axis, wrong region order, and polarity mapping swapped between outputs. A run that rewrites the active width in mid-frame shows that the change lands exactly at the frame wrap and not before. Event pulses, masking and selective clears are driven with the raster stopped, so the vsync source stays silent and each interrupt bit is tested in isolation.

// File: rtl/raster_pkg.sv
package raster_pkg;

    parameter int TW     = 12;
    parameter int POL_W  = 5;
    parameter int NIRQ   = 4;

    typedef logic [TW-1:0] tlen_t;

    typedef enum logic [1:0] {
        RG_SYNC   = 2'd0,
        RG_BACK   = 2'd1,
        RG_ACTIVE = 2'd2,
        RG_FRONT  = 2'd3
    } region_e;

    typedef struct packed {
        tlen_t sync_len;
        tlen_t back_len;
        tlen_t act_len;
        tlen_t front_len;
    } axis_cfg_t;

    localparam logic [3:0] A_CMD    = 4'd0;
    localparam logic [3:0] A_POL    = 4'd1;
    localparam logic [3:0] A_HSYNC  = 4'd2;
    localparam logic [3:0] A_HBACK  = 4'd3;
    localparam logic [3:0] A_HACT   = 4'd4;
    localparam logic [3:0] A_HFRONT = 4'd5;
    localparam logic [3:0] A_VSYNC  = 4'd6;
    localparam logic [3:0] A_VBACK  = 4'd7;
    localparam logic [3:0] A_VACT   = 4'd8;
    localparam logic [3:0] A_VFRONT = 4'd9;
    localparam logic [3:0] A_RAW    = 4'd10;
    localparam logic [3:0] A_CLR    = 4'd11;
    localparam logic [3:0] A_MASK   = 4'd12;
    localparam logic [3:0] A_STAT   = 4'd13;

    localparam int P_VS  = 0;
    localparam int P_HS  = 1;
    localparam int P_DE  = 2;
    localparam int P_DAT = 3;
    localparam int P_CLK = 4;

    localparam int I_FETCH = 0;
    localparam int I_BUS   = 1;
    localparam int I_VS    = 2;
    localparam int I_UNDER = 3;

    localparam logic [POL_W-1:0] POL_RESET = 5'b00111;

    localparam axis_cfg_t H_RESET = '{sync_len: tlen_t'(31), back_len: tlen_t'(79),
                                      act_len: tlen_t'(1679), front_len: tlen_t'(47)};
    localparam axis_cfg_t V_RESET = '{sync_len: tlen_t'(5), back_len: tlen_t'(20),
                                      act_len: tlen_t'(1049), front_len: tlen_t'(2)};

    function automatic region_e next_region(region_e r);
        case (r)
            RG_SYNC:   return RG_BACK;
            RG_BACK:   return RG_ACTIVE;
            RG_ACTIVE: return RG_FRONT;
            default:   return RG_SYNC;
        endcase
    endfunction

    function automatic tlen_t region_len(axis_cfg_t c, region_e r);
        case (r)
            RG_SYNC:   return c.sync_len;
            RG_BACK:   return c.back_len;
            RG_ACTIVE: return c.act_len;
            default:   return c.front_len;
        endcase
    endfunction

endpackage

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      step,
    input  axis_cfg_t cfg,
    output region_e   region,
    output tlen_t     count,
    output logic      last
);

    tlen_t cur_len;

    always_comb begin
        cur_len = region_len(cfg, region);
        last    = step && (region == RG_FRONT) && (count == cur_len);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            region <= RG_SYNC;
            count  <= '0;
        end else if (step) begin
            if (count == cur_len) begin
                count  <= '0;
                region <= next_region(region);
            end else begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/raster_cfg.sv
module raster_cfg
    import raster_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             frame_wrap,
    output logic             en,
    output logic [POL_W-1:0] pol,
    output axis_cfg_t        h_stage,
    output axis_cfg_t        v_stage,
    output axis_cfg_t        h_live,
    output axis_cfg_t        v_live
);

    tlen_t field;
    assign field = wr_data[TW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            pol     <= POL_RESET;
            h_stage <= H_RESET;
            v_stage <= V_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                A_CMD:    en                <= wr_data[0];
                A_POL:    pol               <= wr_data[POL_W-1:0];
                A_HSYNC:  h_stage.sync_len  <= field;
                A_HBACK:  h_stage.back_len  <= field;
                A_HACT:   h_stage.act_len   <= field;
                A_HFRONT: h_stage.front_len <= field;
                A_VSYNC:  v_stage.sync_len  <= field;
                A_VBACK:  v_stage.back_len  <= field;
                A_VACT:   v_stage.act_len   <= field;
                A_VFRONT: v_stage.front_len <= field;
                default: ;
            endcase
        end
    end

    // Live copies follow the staging registers while stopped and at each frame wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            h_live <= H_RESET;
            v_live <= V_RESET;
        end else if (!en || frame_wrap) begin
            h_live <= h_stage;
            v_live <= v_stage;
        end
    end

endmodule

// File: rtl/raster_irq.sv
module raster_irq
    import raster_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] set_vec,
    input  logic            clr_we,
    input  logic [NIRQ-1:0] clr_data,
    input  logic            mask_we,
    input  logic [NIRQ-1:0] mask_data,
    output logic [NIRQ-1:0] raw,
    output logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] status,
    output logic            irq
);

    logic [NIRQ-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_data : '0;
        status  = raw & mask;
        irq     = |status;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_eff) | set_vec;
            if (mask_we) mask <= mask_data;
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [3:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic          ev_fetch_done,
    input  logic          ev_bus_err,
    input  logic          ev_underrun,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          data_pol,
    output logic          pclk_pol,
    output logic [TW-1:0] pos_x,
    output logic [TW-1:0] pos_y,
    output logic          irq
);

    logic             en;
    logic [POL_W-1:0] pol;
    axis_cfg_t        h_stage, v_stage, h_live, v_live;
    region_e          h_reg, v_reg;
    tlen_t            h_cnt, v_cnt;
    logic             h_last, v_last, frame_wrap;
    logic             hs_act, vs_act, act_de, vs_evt;
    logic [NIRQ-1:0]  set_vec, raw, mask, status;
    logic             clr_we, mask_we;

    assign frame_wrap = h_last && v_last;

    raster_cfg #(.AW(4), .DW(32)) i_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_wrap(frame_wrap), .en(en), .pol(pol),
        .h_stage(h_stage), .v_stage(v_stage), .h_live(h_live), .v_live(v_live)
    );

    raster_axis i_hax (
        .clk(clk), .rst(rst), .run(en), .step(1'b1), .cfg(h_live),
        .region(h_reg), .count(h_cnt), .last(h_last)
    );

    raster_axis i_vax (
        .clk(clk), .rst(rst), .run(en), .step(h_last), .cfg(v_live),
        .region(v_reg), .count(v_cnt), .last(v_last)
    );

    always_comb begin
        hs_act   = en && (h_reg == RG_SYNC);
        vs_act   = en && (v_reg == RG_SYNC);
        act_de   = en && (h_reg == RG_ACTIVE) && (v_reg == RG_ACTIVE);
        vs_evt   = vs_act && (v_cnt == '0) && (h_reg == RG_SYNC) && (h_cnt == '0);
        hsync    = hs_act ? pol[P_HS] : ~pol[P_HS];
        vsync    = vs_act ? pol[P_VS] : ~pol[P_VS];
        de       = act_de ? pol[P_DE] : ~pol[P_DE];
        data_pol = pol[P_DAT];
        pclk_pol = pol[P_CLK];
        pos_x    = act_de ? h_cnt : '0;
        pos_y    = act_de ? v_cnt : '0;
    end

    always_comb begin
        set_vec          = '0;
        set_vec[I_FETCH] = ev_fetch_done;
        set_vec[I_BUS]   = ev_bus_err;
        set_vec[I_VS]    = vs_evt;
        set_vec[I_UNDER] = ev_underrun;
        clr_we           = wr_en && (wr_addr == A_CLR);
        mask_we          = wr_en && (wr_addr == A_MASK);
    end

    raster_irq i_irq (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_we(clr_we), .clr_data(wr_data[NIRQ-1:0]),
        .mask_we(mask_we), .mask_data(wr_data[NIRQ-1:0]),
        .raw(raw), .mask(mask), .status(status), .irq(irq)
    );

    always_comb begin
        case (rd_addr)
            A_CMD:    rd_data = 32'(en);
            A_POL:    rd_data = 32'(pol);
            A_HSYNC:  rd_data = 32'(h_stage.sync_len);
            A_HBACK:  rd_data = 32'(h_stage.back_len);
            A_HACT:   rd_data = 32'(h_stage.act_len);
            A_HFRONT: rd_data = 32'(h_stage.front_len);
            A_VSYNC:  rd_data = 32'(v_stage.sync_len);
            A_VBACK:  rd_data = 32'(v_stage.back_len);
            A_VACT:   rd_data = 32'(v_stage.act_len);
            A_VFRONT: rd_data = 32'(v_stage.front_len);
            A_RAW:    rd_data = 32'(raw);
            A_MASK:   rd_data = 32'(mask);
            A_STAT:   rd_data = 32'(status);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
    import raster_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [POL_W-1:0] pol,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic [TW-1:0]    pos_x,
    input logic [TW-1:0]    pos_y,
    input logic             act_de,
    input logic             vs_evt,
    input logic [NIRQ-1:0]  raw,
    input logic [NIRQ-1:0]  set_vec,
    input logic             clr_we,
    input logic [31:0]      wr_data
);

    logic [NIRQ-1:0] clr_bits;
    assign clr_bits = clr_we ? wr_data[NIRQ-1:0] : '0;

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> (hsync == !pol[P_HS]) && (vsync == !pol[P_VS]) && (de == !pol[P_DE])); // R3

    AST_POS_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !act_de |-> (pos_x == '0) && (pos_y == '0)); // R4

    AST_POS_X_STEP: assert property (@(posedge clk) disable iff (rst)
        act_de && $past(act_de) |-> pos_x == $past(pos_x) + 1'b1); // R4

    AST_VS_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vs_evt |=> !vs_evt); // R5

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (raw & $past(raw & ~clr_bits)) == $past(raw & ~clr_bits)); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_bits & ~set_vec) != '0 |=> (raw & $past(clr_bits & ~set_vec)) == '0); // R7

endmodule

bind raster_timing_gen raster_timing_chk i_raster_timing_chk (
    .clk(clk), .rst(rst), .en(en), .pol(pol), .hsync(hsync), .vsync(vsync), .de(de),
    .pos_x(pos_x), .pos_y(pos_y), .act_de(act_de), .vs_evt(vs_evt), .raw(raw),
    .set_vec(set_vec), .clr_we(clr_we), .wr_data(wr_data)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = 4'd10;
    logic [31:0] rd_data;
    logic        ev_fetch_done = 1'b0, ev_bus_err = 1'b0, ev_underrun = 1'b0;
    logic        hsync, vsync, de, data_pol, pclk_pol, irq;
    logic [11:0] pos_x, pos_y;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int ha[4], va[4], hb[4], vb[4];
    logic [4:0] cur_pol = 5'b00111;

    always #5 clk = ~clk;

    raster_timing_gen i_raster_timing_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_fetch_done(ev_fetch_done),
        .ev_bus_err(ev_bus_err), .ev_underrun(ev_underrun), .hsync(hsync), .vsync(vsync),
        .de(de), .data_pol(data_pol), .pclk_pol(pclk_pol), .pos_x(pos_x), .pos_y(pos_y),
        .irq(irq)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge; the write is captured at the next posedge.
    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog_a();
        for (int i = 0; i < 4; i++) begin
            wr(2 + i, ha[i] - 1);
            wr(6 + i, va[i] - 1);
        end
    endtask

    function automatic int sum4(int a[4]);
        return a[0] + a[1] + a[2] + a[3];
    endfunction

    // Runs n cycles from the enable point; optional write at cycle wr_at switches model to hb/vb after first frame.
    task automatic run_check(int n, int wr_at, int wa, int wd, string tag);
        int ht, vt, ft, tt, col, line, hr, vr;
        bit ehs, evs, ede;
        int h[4], v[4];
        rd_addr = 4'd10;
        for (int t = 0; t < n; t++) begin
            ht = sum4(ha); vt = sum4(va); ft = ht * vt;
            h = ha; v = va; tt = t;
            if (wr_at >= 0 && t >= ft) begin
                h = hb; v = vb; tt = t - ft;
                ht = sum4(hb); vt = sum4(vb); ft = ht * vt;
            end
            tt = tt % ft; line = tt / ht; col = tt % ht;
            hr = 0; while (col >= h[hr]) begin col -= h[hr]; hr++; end
            vr = 0; while (line >= v[vr]) begin line -= v[vr]; vr++; end
            ehs = (hr == 0); evs = (vr == 0); ede = (hr == 2) && (vr == 2);
            chk(hsync === (ehs ? cur_pol[1] : !cur_pol[1]), "R1 R2", {tag, " hsync"}, int'(hsync), t);
            chk(vsync === (evs ? cur_pol[0] : !cur_pol[0]), "R1 R2", {tag, " vsync"}, int'(vsync), t);
            chk(de === (ede ? cur_pol[2] : !cur_pol[2]), "R1 R2", {tag, " de"}, int'(de), t);
            chk(pos_x === 12'(ede ? col : 0), "R4", {tag, " pos_x"}, int'(pos_x), ede ? col : 0);
            chk(pos_y === 12'(ede ? line : 0), "R4", {tag, " pos_y"}, int'(pos_y), ede ? line : 0);
            if (t == 0) begin
                chk(rd_data[2] === 1'b0, "R5", {tag, " vs raw before"}, int'(rd_data[2]), 0);
                chk(hsync === cur_pol[1] && vsync === cur_pol[0], "R3", {tag, " restart at sync"},
                    int'({hsync, vsync}), int'({cur_pol[1], cur_pol[0]}));
            end
            if (t == 1)
                chk(rd_data[2] === 1'b1, "R5", {tag, " vs raw after"}, int'(rd_data[2]), 1);
            if (t == wr_at) begin
                wr_en = 1'b1; wr_addr = 4'(wa); wr_data = 32'(wd);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic stop_and_clear(string tag);
        wr(0, 0);
        wr(11, 15);
        for (int k = 0; k < 4; k++) begin
            chk(hsync === !cur_pol[1] && vsync === !cur_pol[0] && de === !cur_pol[2], "R3",
                {tag, " stopped levels"}, int'({hsync, vsync, de}), int'(~cur_pol[2:0]));
            chk(pos_x === 12'd0 && pos_y === 12'd0, "R3", {tag, " stopped pos"}, int'(pos_x), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        int ft;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state
        chk(hsync === 1'b0 && vsync === 1'b0 && de === 1'b0, "R10", "reset levels", int'({hsync, vsync, de}), 0);
        chk(irq === 1'b0 && rd_data === 32'd0, "R8", "reset raw/irq", int'(rd_data), 0);
        rd_addr = 4'd4; #1;
        chk(rd_data === 32'd1679, "R10 R11", "reset hact readback", int'(rd_data), 1679);
        rd_addr = 4'd7; #1;
        chk(rd_data === 32'd20, "R10 R11", "reset vback readback", int'(rd_data), 20);
        rd_addr = 4'd1; #1;
        chk(rd_data === 32'h07, "R10 R11", "reset polarity", int'(rd_data), 7);
        rd_addr = 4'd0; #1;
        chk(rd_data === 32'd0, "R10 R11", "reset command", int'(rd_data), 0);

        // Reference mode, first lines only
        ha = '{32, 80, 1680, 48}; va = '{6, 21, 1050, 3};
        wr(0, 1);
        run_check(3 * 2240, -1, 0, 0, "ref");
        stop_and_clear("ref");

        // Directed small timing
        ha = '{2, 3, 4, 2}; va = '{1, 2, 3, 1};
        prog_a();
        rd_addr = 4'd9; #1;
        chk(rd_data === 32'd0, "R11", "vfront readback", int'(rd_data), 0);
        wr(0, 1);
        run_check(2 * 77 + 5, -1, 0, 0, "small");
        stop_and_clear("small");

        // Every region one unit
        ha = '{1, 1, 1, 1}; va = '{1, 1, 1, 1};
        prog_a();
        wr(0, 1);
        run_check(40, -1, 0, 0, "min");
        stop_and_clear("min");

        // Shadowed timing change in mid-frame
        ha = '{2, 3, 4, 2}; va = '{1, 2, 3, 1};
        prog_a();
        hb = '{2, 3, 6, 2}; vb = va;
        wr(0, 1);
        run_check(77 + 13 * 7, 5, 4, 5, "R9 shadow");
        ha = hb;
        stop_and_clear("shadow");

        // Polarity outputs while stopped
        cur_pol = 5'b11000;
        wr(1, 24);
        chk(hsync === 1'b1 && vsync === 1'b1 && de === 1'b1, "R2", "low-active idle", int'({hsync, vsync, de}), 7);
        chk(data_pol === 1'b1 && pclk_pol === 1'b1, "R2", "data/pclk pol", int'({data_pol, pclk_pol}), 3);

        // Random timings and polarity
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 4; i++) begin
                ha[i] = int'($urandom_range(4, 1));
                va[i] = int'($urandom_range(3, 1));
            end
            cur_pol = 5'($urandom_range(7, 0));
            wr(1, int'(cur_pol));
            prog_a();
            wr(0, 1);
            ft = sum4(ha) * sum4(va);
            run_check(ft + sum4(ha) * 2 + r, -1, 0, 0, "rand");
            stop_and_clear("rand");
        end

        // Interrupt set, mask, clear with the raster stopped
        ev_fetch_done = 1'b1; ev_bus_err = 1'b1;
        @(negedge clk);
        ev_fetch_done = 1'b0; ev_bus_err = 1'b0;
        rd_addr = 4'd10; #1;
        chk(rd_data === 32'd3, "R6", "fetch+bus raw", int'(rd_data), 3);
        rd_addr = 4'd13; #1;
        chk(rd_data === 32'd0 && irq === 1'b0, "R8", "masked off", int'(irq), 0);
        wr(12, 2);
        #1;
        chk(rd_data === 32'd2 && irq === 1'b1, "R8", "mask bus err", int'(rd_data), 2);
        wr(11, 1);
        rd_addr = 4'd10; #1;
        chk(rd_data === 32'd2 && irq === 1'b1, "R7", "clear bit0 only", int'(rd_data), 2);
        wr(11, 2);
        #1;
        chk(rd_data === 32'd0 && irq === 1'b0, "R7", "clear bit1", int'(rd_data), 0);
        ev_underrun = 1'b1;
        @(negedge clk);
        ev_underrun = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_data === 32'd8, "R6", "underrun sticky", int'(rd_data), 8);
        wr(12, 8);
        chk(irq === 1'b1, "R8", "underrun irq", int'(irq), 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule